// File: doc/BRIEF.md
# MSI Event Queue Controller

This block receives posted message-signalled interrupt writes and files each one into one of up to six per-group event queues held in system memory. Each queue is a 64-entry ring of 32-bit words. For every accepted MSI, the block writes the raw data word into the slot at the queue's tail through a memory-write master port. It advances the tail pointer only after that memory write has been accepted. The block keeps one interrupt line per group asserted while the ring holds entries that software has not yet consumed.

Software consumes entries and owns the head pointer. Hardware owns the tail pointer, which software can only read. A register slave port holds the 64-bit base of the queue memory, the 64-bit base of the MSI address window, a per-queue control word, the head and tail pointers, and a legacy per-queue interrupt-enable mask.

The offset of an MSI write within the address window selects its group. The parameter `PAGE_PER_GROUP` chooses between two layouts. In the shared layout, groups are 4 bytes apart in the window and queues are 256 bytes apart in memory. In the paged layout, both are 4096 bytes apart.

Top module: `msi_eq_ctrl`

## Requirements
- R1: After reset, every register and pointer reads zero, `irq` is all zero and `mem_valid` is low.
- R2: Register offsets are as follows.
  - Queue-memory base: low word at 0x200, high word at 0x2C0.
  - MSI-window base: low word at 0x204, high word at 0x2C4.
  - Legacy interrupt-enable mask: 0x208, with bit n for queue n.
  - Control for queue n: 0x210+4n, which keeps bits 0, 1 and 11.
  - Head for queue n: 0x250+8n, writable in its low 6 bits.
  - Tail for queue n: 0x254+8n. Writes to a tail register are ignored.
- R3: In the shared layout, an MSI at window offset 4g targets group g. An MSI whose offset is misaligned, or whose offset names a group at or above `NUM_GROUPS`, is accepted (`msi_ready` high) and dropped without any memory write.
- R4: The memory write for group g goes to queue base + g*256 (shared layout) or g*4096 (paged layout), plus 4 times the tail. Its data is the MSI data word unchanged.
- R5: A tail advances by one only on the cycle after `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the request stays stable. Only one write is outstanding at a time, so `msi_ready` is low while `mem_valid` is high.
- R6: Tail and head are 6-bit pointers, and the tail wraps from 63 to 0.
- R7: A queue holding 63 entries (tail+1 equal to head, modulo 64) is full. An MSI for it is held off with `msi_ready` low until software writes a head value that frees a slot.
- R8: An MSI for a group whose control bit 0 (queue enable) is clear is accepted and dropped, and that group's tail does not move.
- R9: `irq[n]` is high one cycle after all of the following hold, and low one cycle after any of them fails:
  - head and tail of queue n differ;
  - control bits 0, 1 and 11 of queue n are set;
  - when `USE_INTEN` is 1, bit n of the legacy mask is set.

  Writing a head value equal to the tail clears the interrupt.
- R10: With `USE_INTEN`=1, clearing bit n of the legacy mask drops `irq[n]`. With `USE_INTEN`=0, the mask plays no part.
- R11: A head write and a tail advance on the same queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | MSI write request present |
| msi_ready | output | 1 | MSI write taken (stored or dropped) |
| msi_addr | input | 64 | MSI target address |
| msi_data | input | 32 | MSI data word |
| mem_valid | output | 1 | Queue memory write request |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | 64 | Byte address of the queue slot |
| mem_data | output | 32 | Word written to the slot |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | NUM_GROUPS | Per-group interrupt lines |

## Verification
The collision of interest is a software head write that lands in the same cycle as the hardware tail advance on the same queue. The bench stalls a pending queue write by holding `mem_ready` low. It then releases `mem_ready` and writes the head on the same negative edge, so both updates meet at one clock edge. The result is judged by reading back both pointers, which must hold their new values, and by checking that the interrupt stays low because the queue ends up empty. A second collision has a held-off MSI for a full queue waiting while software writes the head. The bench checks that `msi_ready` rises on the next cycle and that the write lands in slot 63, after which the tail reads 0.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
    localparam int PTR_W      = 6;
    localparam int GRP_W      = 3;
    localparam int MAX_GROUPS = 6;
    localparam int SLOT_SH    = 2;

    localparam int CTL_QEN = 0;
    localparam int CTL_EVT = 1;
    localparam int CTL_IRQ = 11;

    localparam logic [11:0] RA_QBASE_LO = 12'h200;
    localparam logic [11:0] RA_QBASE_HI = 12'h2C0;
    localparam logic [11:0] RA_WBASE_LO = 12'h204;
    localparam logic [11:0] RA_WBASE_HI = 12'h2C4;
    localparam logic [11:0] RA_IEN      = 12'h208;
    localparam logic [11:0] RA_CTL0     = 12'h210;
    localparam logic [11:0] RA_HEAD0    = 12'h250;
    localparam logic [11:0] RA_TAIL0    = 12'h254;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic { ST_IDLE, ST_WRITE } eng_state_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [63:0]      addr;
        logic [31:0]      data;
    } slot_req_t;

    function automatic ptr_t ring_count(ptr_t head, ptr_t tail);
        return tail - head;
    endfunction

    function automatic logic ring_full(ptr_t head, ptr_t tail);
        return ptr_t'(tail + 1'b1) == head;
    endfunction
endpackage

// File: rtl/msi_eq_regs.sv
module msi_eq_regs
    import msi_eq_pkg::*;
#(
    parameter int NUM_GROUPS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wen,
    input  logic [11:0]           addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  ptr_t [NUM_GROUPS-1:0] tail_vec,
    output ptr_t [NUM_GROUPS-1:0] head_vec,
    output logic [63:0]           qbase,
    output logic [63:0]           wbase,
    output logic [NUM_GROUPS-1:0] ien,
    output logic [NUM_GROUPS-1:0] qen,
    output logic [NUM_GROUPS-1:0] evten,
    output logic [NUM_GROUPS-1:0] irqen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            qbase <= '0;
            wbase <= '0;
            ien   <= '0;
        end else if (wen) begin
            case (addr)
                RA_QBASE_LO: qbase[31:0]  <= wdata;
                RA_QBASE_HI: qbase[63:32] <= wdata;
                RA_WBASE_LO: wbase[31:0]  <= wdata;
                RA_WBASE_HI: wbase[63:32] <= wdata;
                RA_IEN:      ien          <= wdata[NUM_GROUPS-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_q
        localparam logic [11:0] CTL_A  = RA_CTL0  + 12'(4 * g);
        localparam logic [11:0] HEAD_A = RA_HEAD0 + 12'(8 * g);
        always_ff @(posedge clk) begin
            if (rst) begin
                qen[g]      <= 1'b0;
                evten[g]    <= 1'b0;
                irqen[g]    <= 1'b0;
                head_vec[g] <= '0;
            end else if (wen) begin
                if (addr == CTL_A) begin
                    qen[g]   <= wdata[CTL_QEN];
                    evten[g] <= wdata[CTL_EVT];
                    irqen[g] <= wdata[CTL_IRQ];
                end
                if (addr == HEAD_A) head_vec[g] <= wdata[PTR_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_QBASE_LO: rdata = qbase[31:0];
            RA_QBASE_HI: rdata = qbase[63:32];
            RA_WBASE_LO: rdata = wbase[31:0];
            RA_WBASE_HI: rdata = wbase[63:32];
            RA_IEN:      rdata = 32'(ien);
            default: ;
        endcase
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == RA_CTL0 + 12'(4 * g)) begin
                rdata[CTL_QEN] = qen[g];
                rdata[CTL_EVT] = evten[g];
                rdata[CTL_IRQ] = irqen[g];
            end
            if (addr == RA_HEAD0 + 12'(8 * g)) rdata = 32'(head_vec[g]);
            if (addr == RA_TAIL0 + 12'(8 * g)) rdata = 32'(tail_vec[g]);
        end
    end
endmodule

// File: rtl/msi_eq_decode.sv
module msi_eq_decode
    import msi_eq_pkg::*;
#(
    parameter int NUM_GROUPS     = 6,
    parameter bit PAGE_PER_GROUP = 1'b0
) (
    input  logic [63:0]      msi_addr,
    input  logic [63:0]      wbase,
    output logic             hit,
    output logic [GRP_W-1:0] grp
);
    localparam int SH = PAGE_PER_GROUP ? 12 : 2;

    logic [63:0]    offset;
    logic [63-SH:0] idx;

    always_comb begin
        offset = msi_addr - wbase;
        idx    = offset[63:SH];
        hit    = (offset[SH-1:0] == '0) && (idx < (64-SH)'(NUM_GROUPS));
        grp    = idx[GRP_W-1:0];
    end
endmodule

// File: rtl/msi_eq_ring.sv
module msi_eq_ring
    import msi_eq_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter bit USE_INTEN  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [GRP_W-1:0]      adv_grp,
    input  ptr_t [NUM_GROUPS-1:0] head_vec,
    input  logic [NUM_GROUPS-1:0] qen,
    input  logic [NUM_GROUPS-1:0] evten,
    input  logic [NUM_GROUPS-1:0] irqen,
    input  logic [NUM_GROUPS-1:0] ien,
    output ptr_t [NUM_GROUPS-1:0] tail_vec,
    output logic [NUM_GROUPS-1:0] full_vec,
    output logic [NUM_GROUPS-1:0] irq
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ring
        logic ien_ok;
        logic pending;

        if (USE_INTEN) begin : g_ien
            assign ien_ok = ien[g];
        end else begin : g_noien
            assign ien_ok = 1'b1;
        end

        assign pending     = ring_count(head_vec[g], tail_vec[g]) != '0;
        assign full_vec[g] = ring_full(head_vec[g], tail_vec[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                tail_vec[g] <= '0;
                irq[g]      <= 1'b0;
            end else begin
                if (adv && adv_grp == GRP_W'(g)) tail_vec[g] <= tail_vec[g] + 1'b1;
                irq[g] <= pending && qen[g] && evten[g] && irqen[g] && ien_ok;
            end
        end
    end
endmodule

// File: rtl/msi_eq_ctrl.sv
module msi_eq_ctrl
    import msi_eq_pkg::*;
#(
    parameter int NUM_GROUPS     = 6,
    parameter bit PAGE_PER_GROUP = 1'b0,
    parameter bit USE_INTEN      = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  msi_valid,
    output logic                  msi_ready,
    input  logic [63:0]           msi_addr,
    input  logic [31:0]           msi_data,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [63:0]           mem_addr,
    output logic [31:0]           mem_data,
    input  logic                  reg_wen,
    input  logic [11:0]           reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NUM_GROUPS-1:0] irq
);
    localparam int QSH  = PAGE_PER_GROUP ? 12 : (PTR_W + SLOT_SH);
    localparam int NPAD = 1 << GRP_W;

    ptr_t [NUM_GROUPS-1:0] tail_vec;
    ptr_t [NUM_GROUPS-1:0] head_vec;
    logic [63:0]           qbase, wbase;
    logic [NUM_GROUPS-1:0] ien, qen, evten, irqen, full_vec;
    logic                  hit;
    logic [GRP_W-1:0]      grp;

    eng_state_e state;
    slot_req_t  req;
    logic       store;
    logic       commit;

    logic [NPAD-1:0] qen_pad, full_pad;
    ptr_t [NPAD-1:0] tail_pad;

    msi_eq_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
        .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .tail_vec(tail_vec), .head_vec(head_vec),
        .qbase(qbase), .wbase(wbase), .ien(ien), .qen(qen), .evten(evten), .irqen(irqen)
    );

    msi_eq_decode #(.NUM_GROUPS(NUM_GROUPS), .PAGE_PER_GROUP(PAGE_PER_GROUP)) u_dec (
        .msi_addr(msi_addr), .wbase(wbase), .hit(hit), .grp(grp)
    );

    msi_eq_ring #(.NUM_GROUPS(NUM_GROUPS), .USE_INTEN(USE_INTEN)) u_ring (
        .clk(clk), .rst(rst), .adv(commit), .adv_grp(req.grp), .head_vec(head_vec),
        .qen(qen), .evten(evten), .irqen(irqen), .ien(ien),
        .tail_vec(tail_vec), .full_vec(full_vec), .irq(irq)
    );

    always_comb begin
        qen_pad  = NPAD'(qen);
        full_pad = NPAD'(full_vec);
        tail_pad = '0;
        for (int g = 0; g < NUM_GROUPS; g++) tail_pad[g] = tail_vec[g];
    end

    always_comb begin
        msi_ready = 1'b0;
        store     = 1'b0;
        if (state == ST_IDLE && msi_valid) begin
            if (!hit || !qen_pad[grp]) begin
                msi_ready = 1'b1;
            end else if (!full_pad[grp]) begin
                msi_ready = 1'b1;
                store     = 1'b1;
            end
        end
    end

    assign commit    = (state == ST_WRITE) && mem_ready;
    assign mem_valid = (state == ST_WRITE);
    assign mem_addr  = req.addr;
    assign mem_data  = req.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (store) begin
                    state    <= ST_WRITE;
                    req.grp  <= grp;
                    req.data <= msi_data;
                    req.addr <= qbase + (64'(grp) << QSH) + (64'(tail_pad[grp]) << SLOT_SH);
                end
                ST_WRITE: if (mem_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msi_eq_ctrl_chk.sv
module msi_eq_ctrl_chk #(
    parameter int NUM_GROUPS = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    msi_ready,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [63:0]             mem_addr,
    input logic [31:0]             mem_data,
    input logic [NUM_GROUPS-1:0]   irq,
    input logic [NUM_GROUPS*6-1:0] head_flat,
    input logic [NUM_GROUPS*6-1:0] tail_flat
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_valid && irq == '0));

    a_r5_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !msi_ready);

    a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r5_tail_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(tail_flat) |-> $past(mem_valid && mem_ready));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq
        a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> $past(head_flat[g*6 +: 6] != tail_flat[g*6 +: 6]));
    end
endmodule

bind msi_eq_ctrl msi_eq_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk(clk), .rst(rst), .msi_ready(msi_ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
    .head_flat(head_vec), .tail_flat(tail_vec)
);

// File: tb/tb_msi_eq_ctrl.sv
module tb_msi_eq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_QLO = 12'h200, A_QHI = 12'h2C0, A_WLO = 12'h204, A_WHI = 12'h2C4;
    localparam logic [11:0] A_IEN = 12'h208;
    localparam logic [63:0] QB = 64'h0000_0001_0000_0000;
    localparam logic [63:0] WB = 64'h0000_0000_8000_0000;

    function automatic logic [11:0] a_ctl(int n);  return 12'h210 + 12'(4*n); endfunction
    function automatic logic [11:0] a_head(int n); return 12'h250 + 12'(8*n); endfunction
    function automatic logic [11:0] a_tail(int n); return 12'h254 + 12'(8*n); endfunction

    logic clk = 0, rst = 1;
    logic msi_valid = 0, msi_ready;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic mem_valid, mem_ready = 1;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic reg_wen = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [5:0] irq;

    logic p_msi_valid = 0, p_msi_ready;
    logic [63:0] p_msi_addr = '0;
    logic p_mem_valid;
    logic [63:0] p_mem_addr;
    logic [31:0] p_mem_data;
    logic p_reg_wen = 0;
    logic [11:0] p_reg_addr = '0;
    logic [31:0] p_reg_wdata = '0, p_reg_rdata;
    logic [5:0] p_irq;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_eq_ctrl dut (
        .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_addr(msi_addr), .msi_data(msi_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    msi_eq_ctrl #(.PAGE_PER_GROUP(1'b1), .USE_INTEN(1'b0)) dut_pg (
        .clk(clk), .rst(rst), .msi_valid(p_msi_valid), .msi_ready(p_msi_ready),
        .msi_addr(p_msi_addr), .msi_data(32'h5555_0042), .mem_valid(p_mem_valid),
        .mem_ready(1'b1), .mem_addr(p_mem_addr), .mem_data(p_mem_data),
        .reg_wen(p_reg_wen), .reg_addr(p_reg_addr), .reg_wdata(p_reg_wdata),
        .reg_rdata(p_reg_rdata), .irq(p_irq)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wen = 0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic send_msi(input logic [63:0] a, input logic [31:0] d, output logic acc,
                            output logic mv, output logic [63:0] ma, output logic [31:0] md);
        int n = 0;
        @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d;
        #1;
        while (!msi_ready && n < 8) begin @(negedge clk); #1; n++; end
        acc = msi_ready;
        @(negedge clk); msi_valid = 0; #1;
        mv = mem_valid; ma = mem_addr; md = mem_data;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(a_tail(0), v);  check(v == 0, "R1 tail0 after reset", 64'(v), 0);
        reg_read(a_head(3), v);  check(v == 0, "R1 head3 after reset", 64'(v), 0);
        reg_read(a_ctl(2), v);   check(v == 0, "R1 ctl2 after reset", 64'(v), 0);
        check(irq == 0, "R1 irq after reset", 64'(irq), 0);
        check(!mem_valid, "R1 mem_valid after reset", 64'(mem_valid), 0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        reg_write(A_QLO, QB[31:0]); reg_write(A_QHI, QB[63:32]);
        reg_write(A_WLO, WB[31:0]); reg_write(A_WHI, WB[63:32]);
        reg_write(A_IEN, 32'h3F);
        for (int g = 0; g < 6; g++) reg_write(a_ctl(g), 32'hFFFF_FFFF);
        reg_read(a_ctl(4), v);  check(v == 32'h803, "R2 ctl readback keeps bits 0,1,11", 64'(v), 64'h803);
        reg_read(A_QHI, v);     check(v == 1, "R2 queue base high", 64'(v), 1);
        reg_write(a_tail(0), 32'h5);
        reg_read(a_tail(0), v); check(v == 0, "R2 tail write ignored", 64'(v), 0);
    endtask

    task automatic t_basic;
        logic acc, mv; logic [63:0] ma; logic [31:0] md, v;
        send_msi(WB, 32'hABCD_0123, acc, mv, ma, md);
        check(mv && ma == QB, "R4 group0 slot0 address", ma, QB);
        check(md == 32'hABCD_0123, "R4 data unchanged", 64'(md), 64'hABCD_0123);
        reg_read(a_tail(0), v); check(v == 1, "R5 tail0 advanced", 64'(v), 1);
        send_msi(WB + 8, 32'h0000_0040, acc, mv, ma, md);
        check(mv && ma == QB + 64'h200, "R3 offset 8 selects group2", ma, QB + 64'h200);
        tick(2);
        check(irq == 6'b000101, "R9 irq for groups 0 and 2", 64'(irq), 64'h5);
        reg_write(a_head(0), 1);
        tick(1);
        check(irq == 6'b000100, "R9 head equal tail clears irq0", 64'(irq), 64'h4);
        reg_write(A_IEN, 32'h3B);
        tick(1);
        check(irq[2] == 0, "R10 legacy mask bit2 drops irq2", 64'(irq), 0);
        reg_write(A_IEN, 32'h3F);
        tick(1);
        check(irq[2] == 1, "R10 legacy mask restored", 64'(irq), 64'h4);
    endtask

    task automatic t_drop;
        logic acc, mv; logic [63:0] ma; logic [31:0] md, v;
        send_msi(WB + 24, 32'h1, acc, mv, ma, md);
        check(acc && !mv, "R3 group 6 out of range dropped", 64'(mv), 0);
        send_msi(WB + 6, 32'h1, acc, mv, ma, md);
        check(acc && !mv, "R3 misaligned offset dropped", 64'(mv), 0);
        reg_write(a_ctl(1), 32'h802);
        send_msi(WB + 4, 32'h1, acc, mv, ma, md);
        check(acc && !mv, "R8 disabled queue dropped", 64'(mv), 0);
        reg_read(a_tail(1), v); check(v == 0, "R8 disabled tail unchanged", 64'(v), 0);
    endtask

    task automatic t_backpressure;
        logic acc, mv; logic [63:0] ma; logic [31:0] md, v;
        mem_ready = 0;
        send_msi(WB + 12, 32'h77, acc, mv, ma, md);
        tick(2);
        #1 check(mem_valid && mem_addr == QB + 64'h300, "R5 request held under stall", mem_addr, QB + 64'h300);
        reg_read(a_tail(3), v); check(v == 0, "R5 no tail advance before commit", 64'(v), 0);
        mem_ready = 1;
        tick(1);
        reg_read(a_tail(3), v); check(v == 1, "R5 tail advances after commit", 64'(v), 1);
    endtask

    task automatic t_full_wrap;
        logic acc, mv; logic [63:0] ma; logic [31:0] md, v;
        logic stalled = 1;
        for (int i = 0; i < 63; i++) begin
            send_msi(WB + 16, 32'(i), acc, mv, ma, md);
            if (i == 62) check(ma == QB + 64'h400 + 64'd248, "R4 slot 62 address", ma, QB + 64'h4F8);
        end
        @(negedge clk); msi_valid = 1; msi_addr = WB + 16; msi_data = 32'hF00D;
        for (int i = 0; i < 4; i++) begin #1 if (msi_ready) stalled = 0; @(negedge clk); end
        check(stalled, "R7 full queue holds off MSI", 64'(stalled), 1);
        reg_wen = 1; reg_addr = a_head(4); reg_wdata = 1;
        @(negedge clk); reg_wen = 0;
        #1 check(msi_ready, "R7 freed slot releases MSI", 64'(msi_ready), 1);
        @(negedge clk); msi_valid = 0;
        #1 check(mem_addr == QB + 64'h4FC, "R6 slot 63 address", mem_addr, QB + 64'h4FC);
        tick(1);
        reg_read(a_tail(4), v); check(v == 0, "R6 tail wraps to 0", 64'(v), 0);
    endtask

    task automatic t_collide;
        logic acc, mv; logic [63:0] ma; logic [31:0] md, v;
        mem_ready = 0;
        send_msi(WB + 20, 32'h99, acc, mv, ma, md);
        @(negedge clk); mem_ready = 1; reg_wen = 1; reg_addr = a_head(5); reg_wdata = 1;
        @(negedge clk); reg_wen = 0;
        reg_read(a_tail(5), v); check(v == 1, "R11 tail advanced in collision", 64'(v), 1);
        reg_read(a_head(5), v); check(v == 1, "R11 head written in collision", 64'(v), 1);
        tick(1);
        check(irq[5] == 0, "R11 queue empty so irq5 low", 64'(irq), 0);
    endtask

    task automatic p_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); p_reg_wen = 1; p_reg_addr = a; p_reg_wdata = d;
        @(negedge clk); p_reg_wen = 0;
    endtask

    task automatic t_paged;
        p_write(A_QLO, 32'h1000_0000);
        p_write(A_WLO, 32'h4000_0000);
        p_write(a_ctl(2), 32'h803);
        @(negedge clk); p_msi_valid = 1; p_msi_addr = 64'h4000_2000;
        #1 check(p_msi_ready, "R3 paged group2 accepted", 64'(p_msi_ready), 1);
        @(negedge clk); p_msi_valid = 0;
        #1 check(p_mem_valid && p_mem_addr == 64'h1000_2000, "R4 paged group2 address", p_mem_addr, 64'h1000_2000);
        check(p_mem_data == 32'h5555_0042, "R4 paged data unchanged", 64'(p_mem_data), 64'h5555_0042);
        tick(3);
        check(p_irq == 6'b000100, "R10 no legacy mask needed", 64'(p_irq), 64'h4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        t_reset();
        t_config();
        t_basic();
        t_drop();
        t_backpressure();
        t_full_wrap();
        t_collide();
        t_paged();
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule